// File: doc/BRIEF.md
# Prescaled Periodic Update Timer

This block is an up-counting timer that raises a periodic update event. A prescaler divides the input clock. The main counter then counts prescaled ticks from zero up to a reload limit and returns to zero. Each return to zero is marked by a one-cycle update pulse. The same event sets a sticky status flag. The interrupt request is the flag masked by an interrupt-enable bit, so the request stays high until software writes a clear.

Software drives the block through a single-cycle write strobe, a 2-bit register select and a 32-bit data word. Select 0 is the control word: bit 0 enables counting and bit 1 enables the interrupt. Select 1 is the prescale value and select 2 is the reload limit. Select 3 is the status word, where writing bit 0 as 0 clears the flag. A control write with bit 0 at 0 stops the timer and zeroes both counters. Prescale and reload values written while the timer runs are held in pending registers and are adopted at the next update event. While the timer is stopped, they are adopted continuously.

The run controller has two states. HALT is the reset state, in which both counters are held at zero. COUNT is the state in which the counters advance. The transition START (HALT to COUNT) is taken on a control write with bit 0 set. The transition STOP (COUNT to HALT) is taken on a control write with bit 0 clear. Any other write leaves the state unchanged.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset, the count output is 0, the update pulse is low and the interrupt request is low.
- R2: While the timer is stopped, the count stays at 0 and no update pulse appears.
- R3: Consecutive update pulses are (P+1)*(A+1) cycles apart, where P is the prescale value and A is the reload value. The first pulse comes that many cycles after the clock edge that accepts the enabling control write. With P=0 and A=0 the pulse is high on every cycle.
- R4: The count rises by one on each prescaled tick, goes from A back to 0 at the update event, and reads 0 in the cycle in which the update pulse is high.
- R5: Each update event sets the status flag. The flag stays set until a status write (select 3) with bit 0 at 0. A status write with bit 0 at 1 leaves it unchanged.
- R6: When a flag clear and an update event fall on the same clock edge, the flag ends that edge set.
- R7: The interrupt request is high only while the flag is set and control bit 1 is 1.
- R8: A control write (select 0) with bit 0 at 0 zeroes the count at the edge that accepts it. It does not change the flag.
- R9: A prescale (select 1) or reload (select 2) value written while the timer runs does not change the period in progress. It sets the length of the periods that follow.
- R10: With P=83 and A=999, the update period is exactly 84,000 input clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 control, 1 prescale, 2 reload, 3 status |
| wr_data | input | 32 | Write data |
| count_o | output | 32 | Current main counter value |
| update_o | output | 1 | One-cycle pulse per update event |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong internal state shows up at the ports as a mistimed update pulse or a count that breaks its 0..A staircase. A prescaler that is off by one, or a reload limit adopted at the wrong time, moves the next pulse by a whole number of cycles. A lost or spurious flag shows up on the interrupt request in the cycle after the faulty edge, as long as the interrupt enable is on. The bench therefore measures pulse intervals to the exact cycle. It samples the interrupt request one cycle after each status or control write.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_PSC  = 2'd1,
        SEL_ARR  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int STAT_FLAG_BIT = 0;
endpackage

// File: rtl/ptmr_run_fsm.sv
module ptmr_run_fsm
    import ptmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic en_bit,
    output logic run,
    output logic halt
);
    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (ctrl_wr && en_bit)  state_d = ST_COUNT;
            ST_COUNT: if (ctrl_wr && !en_bit) state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        run  = (state_q == ST_COUNT);
        halt = ctrl_wr && !en_bit;
    end
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         halt,
    input  logic         reload,
    input  logic [W-1:0] div_in,
    output logic         tick
);
    logic [W-1:0] div_q;
    logic [W-1:0] pcnt_q;

    assign tick = run && !halt && (pcnt_q == div_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            pcnt_q <= '0;
        end else begin
            if (!run || reload) div_q <= div_in;
            if (!run || halt)   pcnt_q <= '0;
            else if (tick)      pcnt_q <= '0;
            else                pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptmr_wrap_counter.sv
module ptmr_wrap_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         halt,
    input  logic         tick,
    input  logic [W-1:0] lim_in,
    output logic [W-1:0] cnt_o,
    output logic         evt_o
);
    logic [W-1:0] lim_q;
    logic [W-1:0] cnt_q;

    assign evt_o = tick && (cnt_q == lim_q);
    assign cnt_o = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
            cnt_q <= '0;
        end else begin
            if (!run || evt_o) lim_q <= lim_in;
            if (!run || halt)  cnt_q <= '0;
            else if (evt_o)    cnt_q <= '0;
            else if (tick)     cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             update_o,
    output logic             irq_o
);
    logic             ctrl_wr, clr_req;
    logic             run, halt, tick, evt;
    logic [CNT_W-1:0] psc_pend, arr_pend;
    logic             ie_q, flag_q, upd_q;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign clr_req = wr_en && (wr_sel == SEL_STAT) && !wr_data[STAT_FLAG_BIT];

    ptmr_run_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .en_bit  (wr_data[CTRL_EN_BIT]),
        .run     (run),
        .halt    (halt)
    );

    ptmr_prescaler #(.W(CNT_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .halt   (halt),
        .reload (evt),
        .div_in (psc_pend),
        .tick   (tick)
    );

    ptmr_wrap_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .halt   (halt),
        .tick   (tick),
        .lim_in (arr_pend),
        .cnt_o  (count_o),
        .evt_o  (evt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_pend <= '0;
            arr_pend <= '0;
            ie_q     <= 1'b0;
            flag_q   <= 1'b0;
            upd_q    <= 1'b0;
        end else begin
            if (wr_en && wr_sel == SEL_PSC) psc_pend <= wr_data;
            if (wr_en && wr_sel == SEL_ARR) arr_pend <= wr_data;
            if (ctrl_wr) ie_q <= wr_data[CTRL_IE_BIT];
            if (evt)          flag_q <= 1'b1;
            else if (clr_req) flag_q <= 1'b0;
            upd_q <= evt;
        end
    end

    assign update_o = upd_q;
    assign irq_o    = flag_q && ie_q;
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         evt,
    input logic         flag_q,
    input logic         clr_req,
    input logic [W-1:0] count_o,
    input logic         update_o,
    input logic         irq_o
);
    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (count_o == '0 && !update_o)); // R2
    AST_UPD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (count_o == '0)); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (count_o == '0 || count_o == $past(count_o)
                                 || count_o == $past(count_o) + 1'b1)); // R4
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (flag_q && update_o)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q); // R5
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_q); // R7
endmodule

bind periodic_tick_timer ptmr_checker #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .evt      (evt),
    .flag_q   (flag_q),
    .clr_req  (clr_req),
    .count_o  (count_o),
    .update_o (update_o),
    .irq_o    (irq_o)
);

// File: tb/periodic_tick_timer_tb.sv
module periodic_tick_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_WAIT   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] count_o;
    logic        update_o, irq_o;

    int total = 0;
    int bad   = 0;

    periodic_tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count_o(count_o), .update_o(update_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One write: driven at a falling edge, accepted at the next rising edge.
    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Falling edges until update_o is seen high.
    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!update_o && n < MAX_WAIT);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", count_o, 0);
        chk("R1 update", update_o, 0);
        chk("R1 irq", irq_o, 0);
    endtask

    task automatic t_stopped();
        do_reset();
        wr(2'd1, 0); wr(2'd2, 2);
        repeat (10) @(negedge clk);
        chk("R2 count held", count_o, 0);
        chk("R2 no update", update_o, 0);
    endtask

    task automatic t_every_cycle();
        int n;
        do_reset();
        wr(2'd1, 0); wr(2'd2, 0); wr(2'd0, 32'h1);
        measure(n); chk("R3 P0A0 first", n, 1);
        measure(n); chk("R3 P0A0 next", n, 1);
    endtask

    task automatic t_staircase();
        int n;
        do_reset();
        wr(2'd1, 3); wr(2'd2, 4); wr(2'd0, 32'h1);
        measure(n); chk("R3 first after enable", n, 20);
        chk("R4 count at update", count_o, 0);
        repeat (4) @(negedge clk);
        chk("R4 count after one tick", count_o, 1);
        measure(n); chk("R3 remainder", n, 16);
        measure(n); chk("R3 full period", n, 20);
    endtask

    task automatic t_flag();
        int n;
        do_reset();
        wr(2'd1, 1); wr(2'd2, 1); wr(2'd0, 32'h1);   // run, irq enable off
        measure(n); chk("R3 P1A1", n, 4);
        chk("R7 masked", irq_o, 0);
        wr(2'd0, 32'h2);                             // stop, irq enable on
        chk("R8 flag kept over stop", irq_o, 1);
        chk("R8 count zero", count_o, 0);
        repeat (5) @(negedge clk);
        chk("R5 sticky", irq_o, 1);
        chk("R2 stopped count", count_o, 0);
        wr(2'd3, 32'h1);
        chk("R5 write one ignored", irq_o, 1);
        wr(2'd3, 32'h0);
        chk("R5 cleared", irq_o, 0);
    endtask

    task automatic t_set_wins();
        int n;
        do_reset();
        wr(2'd1, 0); wr(2'd2, 0); wr(2'd0, 32'h3);
        measure(n);
        wr(2'd3, 32'h0);                             // clear on an edge that also updates
        chk("R6 set wins", irq_o, 1);
    endtask

    task automatic t_halt();
        do_reset();
        wr(2'd1, 0); wr(2'd2, 99); wr(2'd0, 32'h1);
        repeat (10) @(negedge clk);
        chk("R4 count rising", count_o, 10);
        wr(2'd0, 32'h0);
        chk("R8 zeroed at stop", count_o, 0);
        repeat (5) @(negedge clk);
        chk("R8 stays zero", count_o, 0);
        chk("R2 no update after stop", update_o, 0);
    endtask

    task automatic t_shadow();
        int n;
        do_reset();
        wr(2'd1, 0); wr(2'd2, 9); wr(2'd0, 32'h1);
        measure(n); chk("R3 A9", n, 10);
        wr(2'd2, 3);                                 // 2 cycles of the old period spent here
        measure(n); chk("R9 old period kept", n, 8);
        measure(n); chk("R9 new period", n, 4);
    endtask

    task automatic t_millisecond();
        int n;
        do_reset();
        wr(2'd1, 83); wr(2'd2, 999); wr(2'd0, 32'h1);
        measure(n); chk("R10 84000 cycles", n, 84000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_stopped();
        t_every_cycle();
        t_staircase();
        t_flag();
        t_set_wins();
        t_halt();
        t_shadow();
        t_millisecond();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule